// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block turns a stream of master-rate ticks into a sample strobe at a lower rate. Two master tick inputs arrive as single-cycle enables: one running at 44.1 kHz and one at 48 kHz. A one-bit source register picks which of the two drives the block. A 32-bit divider register sets the ratio `inc / mod`, so the strobe rate is `master * inc / mod`. With `inc = 4` and `mod = 4 * master / rate`, output rates from 8 kHz up to the master rate can be produced.

The divider does not store `mod` directly. It stores `inc` in the low half and the 16-bit two's-complement value `inc - mod - 1` in the high half. Inside, the block keeps a fractional accumulator. On each selected master tick it adds `inc`. When the sum reaches `mod`, it subtracts `mod` and fires one strobe. The stored negative term turns the threshold test into one addition followed by a sign check. Two instances, one for playback and one for record, can run side by side with independent settings.

Top module: `bres_rate_gen`

## Requirements
- R1: After reset, `sample_stb` is 0. The source register selects the 48 kHz tick (value 0). The divider holds `inc = 0` and a high half of `16'hFFFF`, which gives `mod = 0`, so `cfg_err` is 1.
- R2: Source bit value 1 selects `tick_441` and value 0 selects `tick_480`. A tick on the unselected line has no effect on the strobe or on the accumulator.
- R3: The divider word holds `inc` in bits 15:0 and `(inc - mod - 1) & 16'hFFFF` in bits 31:16. The block recovers `mod` as `inc - sext(hi) - 1`.
- R4: On each selected tick of a valid configuration, the accumulator adds `inc`. If the sum is at least `mod`, `mod` is subtracted and `sample_stb` is high for exactly the one clock after that tick. Otherwise `sample_stb` is low in that clock.
- R5: Starting from a cleared accumulator, every run of `mod` selected ticks produces exactly `inc` strobes.
- R6: A configuration with `inc > mod` (bit 31 of the divider clear) or with `mod = 0` raises `cfg_err`, and while it holds, no strobe is produced.
- R7: A write to either register clears the accumulator to 0. A selected tick in the same cycle as a write is discarded.
- R8: When `inc = mod` (high half `16'hFFFF`), every selected tick produces a strobe.
- R9: `sample_stb` is never high unless the previous cycle held a selected tick with a valid configuration and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_441 | input | 1 | 44.1 kHz master tick enable |
| tick_480 | input | 1 | 48 kHz master tick enable |
| sel_wr | input | 1 | Write strobe for the source register |
| sel_wdata | input | 1 | Source value: 1 selects tick_441, 0 selects tick_480 |
| div_wr | input | 1 | Write strobe for the divider register |
| div_wdata | input | 32 | Divider word: {inc - mod - 1, inc} |
| sample_stb | output | 1 | One-cycle sample strobe |
| cfg_err | output | 1 | High while the divider setting is invalid |

## Verification
A register write and a selected master tick can arrive in the same cycle. The write must win: the accumulator clears and the tick is lost. The bench provokes this in a state one tick short of a strobe, using `inc = 4` and `mod = 8` with the accumulator at 4. It fires the tick together with a divider write, and again together with a source write. Each time it expects no strobe on the colliding tick, none on the next tick, and a strobe on the tick after that. A counted tick, or an uncleared accumulator, would instead give an early strobe.

// File: rtl/bres_rate_pkg.sv
package bres_rate_pkg;

    typedef enum logic {
        SRC_48K = 1'b0,
        SRC_44K = 1'b1
    } src_e;

endpackage

// File: rtl/bres_rate_cfg.sv
module bres_rate_cfg
    import bres_rate_pkg::*;
#(
    parameter int INC_W = 16,
    localparam int DIV_W = 2 * INC_W,
    localparam int MOD_W = INC_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic             sel_wdata,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output src_e             src_o,
    output logic [INC_W-1:0] inc_o,
    output logic [MOD_W-1:0] mod_o,
    output logic [MOD_W-1:0] step_o,
    output logic             bad_o,
    output logic             wr_o
);

    typedef struct packed {
        src_e             src;
        logic [INC_W-1:0] neg;
        logic [INC_W-1:0] inc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [MOD_W-1:0] neg_ext;

    always_comb begin
        cfg_d = cfg_q;
        if (sel_wr) begin
            cfg_d.src = src_e'(sel_wdata);
        end
        if (div_wr) begin
            cfg_d.neg = div_wdata[DIV_W-1:INC_W];
            cfg_d.inc = div_wdata[INC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{src: SRC_48K, neg: '1, inc: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // neg = inc - mod - 1, so step = inc - mod = neg + 1 and mod = inc - neg - 1
    assign neg_ext = {{(MOD_W-INC_W){cfg_q.neg[INC_W-1]}}, cfg_q.neg};
    assign step_o  = neg_ext + MOD_W'(1);
    assign mod_o   = {{(MOD_W-INC_W){1'b0}}, cfg_q.inc} - neg_ext - MOD_W'(1);
    assign bad_o   = !cfg_q.neg[INC_W-1] || (mod_o == '0);
    assign inc_o   = cfg_q.inc;
    assign src_o   = cfg_q.src;
    assign wr_o    = sel_wr || div_wr;

endmodule

// File: rtl/bres_rate_tick_mux.sv
module bres_rate_tick_mux
    import bres_rate_pkg::*;
(
    input  logic tick_441,
    input  logic tick_480,
    input  src_e src,
    output logic tick_o
);

    always_comb begin
        unique case (src)
            SRC_44K: tick_o = tick_441;
            default: tick_o = tick_480;
        endcase
    end

endmodule

// File: rtl/bres_rate_accum.sv
module bres_rate_accum #(
    parameter int INC_W = 16,
    localparam int MOD_W = INC_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             bad,
    input  logic [INC_W-1:0] inc,
    input  logic [MOD_W-1:0] step,
    output logic             stb_o,
    output logic [MOD_W-1:0] acc_o
);

    typedef struct packed {
        logic [MOD_W-1:0] acc;
        logic             stb;
    } acc_t;

    acc_t st_d, st_q;
    logic [MOD_W-1:0] trial;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        trial    = st_q.acc + step;
        if (clr) begin
            st_d.acc = '0;
        end else if (tick && !bad) begin
            if (!trial[MOD_W-1]) begin
                st_d.acc = trial;
                st_d.stb = 1'b1;
            end else begin
                st_d.acc = st_q.acc + {{(MOD_W-INC_W){1'b0}}, inc};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o = st_q.stb;
    assign acc_o = st_q.acc;

endmodule

// File: rtl/bres_rate_gen.sv
module bres_rate_gen
    import bres_rate_pkg::*;
#(
    parameter int INC_W = 16,
    localparam int DIV_W = 2 * INC_W,
    localparam int MOD_W = INC_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_441,
    input  logic             tick_480,
    input  logic             sel_wr,
    input  logic             sel_wdata,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             sample_stb,
    output logic             cfg_err
);

    src_e             src;
    logic [INC_W-1:0] inc_val;
    logic [MOD_W-1:0] mod_val;
    logic [MOD_W-1:0] step_val;
    logic [MOD_W-1:0] acc_val;
    logic             cfg_wr;
    logic             tick_sel;

    bres_rate_cfg #(.INC_W(INC_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .src_o     (src),
        .inc_o     (inc_val),
        .mod_o     (mod_val),
        .step_o    (step_val),
        .bad_o     (cfg_err),
        .wr_o      (cfg_wr)
    );

    bres_rate_tick_mux u_mux (
        .tick_441 (tick_441),
        .tick_480 (tick_480),
        .src      (src),
        .tick_o   (tick_sel)
    );

    bres_rate_accum #(.INC_W(INC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_wr),
        .tick  (tick_sel),
        .bad   (cfg_err),
        .inc   (inc_val),
        .step  (step_val),
        .stb_o (sample_stb),
        .acc_o (acc_val)
    );

endmodule

// File: rtl/bres_rate_gen_chk.sv
module bres_rate_gen_chk #(
    parameter int MOD_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_sel,
    input logic             sel_wr,
    input logic             div_wr,
    input logic             cfg_err,
    input logic             sample_stb,
    input logic [MOD_W-1:0] acc_val,
    input logic [MOD_W-1:0] mod_val
);

    // R9
    stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(tick_sel && !sel_wr && !div_wr && !cfg_err));

    // R6
    err_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !sample_stb);

    // R7
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr || div_wr) |=> (acc_val == '0 && !sample_stb));

    // R4
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_err |-> (acc_val < mod_val));

endmodule

bind bres_rate_gen bres_rate_gen_chk #(.MOD_W(MOD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_sel   (tick_sel),
    .sel_wr     (sel_wr),
    .div_wr     (div_wr),
    .cfg_err    (cfg_err),
    .sample_stb (sample_stb),
    .acc_val    (acc_val),
    .mod_val    (mod_val)
);

// File: tb/bres_rate_gen_bench.sv
module bres_rate_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_441 = 1'b0;
    logic        tick_480 = 1'b0;
    logic        sel_wr = 1'b0;
    logic        sel_wdata = 1'b0;
    logic        div_wr = 1'b0;
    logic [31:0] div_wdata = '0;
    logic        sample_stb;
    logic        cfg_err;

    int n_run = 0;
    int n_fail = 0;
    int m_acc, m_inc, m_mod;
    bit m_sel;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bres_rate_gen u_bres_rate_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_441   (tick_441),
        .tick_480   (tick_480),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .div_wr     (div_wr),
        .div_wdata  (div_wdata),
        .sample_stb (sample_stb),
        .cfg_err    (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_sel(input bit v);
        @(negedge clk);
        sel_wr = 1'b1; sel_wdata = v;
        @(negedge clk);
        sel_wr = 1'b0;
        m_sel = v; m_acc = 0;
    endtask

    // R3 field layout: {inc - mod - 1, inc}
    task automatic write_div(input int inc, input int mod);
        @(negedge clk);
        div_wr = 1'b1; div_wdata = {16'(inc - mod - 1), 16'(inc)};
        @(negedge clk);
        div_wr = 1'b0;
        m_inc = inc; m_mod = mod; m_acc = 0;
    endtask

    // one tick on the chosen line; strobe is sampled one clock later
    task automatic tick(input bit on441, output bit got);
        @(negedge clk);
        tick_441 = on441; tick_480 = !on441;
        @(negedge clk);
        tick_441 = 1'b0; tick_480 = 1'b0;
        got = sample_stb;
    endtask

    function automatic bit model_tick();
        m_acc += m_inc;
        if (m_acc >= m_mod) begin
            m_acc -= m_mod;
            return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic t_reset();
        bit g;
        check(sample_stb == 1'b0, "R1 stb after reset", sample_stb, 0);
        check(cfg_err == 1'b1, "R1 err after reset", cfg_err, 1);
        tick(1'b0, g);
        check(g == 1'b0, "R6 no strobe with reset config", g, 0);
    endtask

    task automatic t_rate(input bit sel, input int inc, input int mod, input string req);
        bit g, e;
        int cnt, mism;
        write_sel(sel);
        write_div(inc, mod);
        check(cfg_err == 1'b0, "R3 valid fields decode", cfg_err, 0);
        for (int w = 0; w < 2; w++) begin
            cnt = 0; mism = 0;
            for (int i = 0; i < mod; i++) begin
                tick(sel, g);
                e = model_tick();
                if (g != e) mism++;
                if (g) cnt++;
            end
            check(mism == 0, {req, " R4 strobe pattern"}, mism, 0);
            check(cnt == inc, {req, " R5 strobes per mod ticks"}, cnt, inc);
        end
    endtask

    task automatic t_every_tick();
        bit g;
        int cnt = 0;
        write_sel(1'b1);
        write_div(4, 4);
        for (int i = 0; i < 6; i++) begin
            tick(1'b1, g);
            if (g) cnt++;
        end
        check(cnt == 6, "R8 inc==mod strobes every tick", cnt, 6);
    endtask

    task automatic t_unselected();
        bit g;
        write_sel(1'b1);
        write_div(4, 8);
        tick(1'b0, g);
        check(g == 1'b0, "R2 unselected 480 no strobe", g, 0);
        tick(1'b1, g);
        check(g == 1'b0, "R2 unselected tick left acc untouched", g, 0);
        tick(1'b1, g);
        check(g == 1'b1, "R2 selected 441 second tick strobes", g, 1);
        write_sel(1'b0);
        tick(1'b1, g);
        check(g == 1'b0, "R2 unselected 441 no strobe", g, 0);
        tick(1'b0, g);
        check(g == 1'b0, "R2 first 480 tick", g, 0);
        tick(1'b0, g);
        check(g == 1'b1, "R2 second 480 tick strobes", g, 1);
    endtask

    task automatic t_invalid();
        bit g;
        int cnt = 0;
        write_sel(1'b0);
        write_div(5, 4);
        check(cfg_err == 1'b1, "R6 inc>mod flagged", cfg_err, 1);
        for (int i = 0; i < 8; i++) begin
            tick(1'b0, g);
            if (g) cnt++;
        end
        check(cnt == 0, "R6 inc>mod silent", cnt, 0);
        write_div(0, 0);
        check(cfg_err == 1'b1, "R6 mod zero flagged", cfg_err, 1);
        tick(1'b0, g);
        check(g == 1'b0, "R6 mod zero silent", g, 0);
    endtask

    task automatic t_collide(input bit use_sel);
        bit g;
        write_sel(1'b0);
        write_div(4, 8);
        tick(1'b0, g);
        check(g == 1'b0, "R7 setup tick", g, 0);
        @(negedge clk);
        tick_480 = 1'b1;
        if (use_sel) begin
            sel_wr = 1'b1; sel_wdata = 1'b0;
        end else begin
            div_wr = 1'b1; div_wdata = {16'(4 - 8 - 1), 16'(4)};
        end
        @(negedge clk);
        tick_480 = 1'b0; sel_wr = 1'b0; div_wr = 1'b0;
        check(sample_stb == 1'b0, "R7 colliding tick discarded", sample_stb, 0);
        tick(1'b0, g);
        check(g == 1'b0, "R7 accumulator cleared", g, 0);
        tick(1'b0, g);
        check(g == 1'b1, "R7 strobe after two fresh ticks", g, 1);
    endtask

    task automatic t_idle();
        int seen = 0;
        write_sel(1'b1);
        write_div(4, 4);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (sample_stb) seen++;
        end
        check(seen == 0, "R9 no strobe without tick", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rate(1'b1, 4, 8, "44k1/22050");
        t_rate(1'b0, 4, 24, "48k/8000");
        t_rate(1'b1, 4, 5, "44k1/mod5");
        t_rate(1'b0, 3, 13, "48k/3of13");
        t_every_tick();
        t_unselected();
        t_invalid();
        t_collide(1'b0);
        t_collide(1'b1);
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule